// File: doc/BRIEF.md
# Shared-Engine Multi-Endpoint SPI Master with Single, Dual and Quad Lanes

One serial engine serves several SPI peripherals. Each peripheral has its own active-low chip select and its own serial clock line, and all of them share one 4-lane data bus. That bus is presented as a 4-bit output, one output-enable per endpoint and a 4-bit input per endpoint, so the pads can be tri-stated at the top level. Only one transaction runs at a time because every endpoint uses the same configuration and the same byte store.

Software first fills a byte store through a plain write port. It then presents the endpoint index, the lane mode, the transmit and receive byte counts and a clock prescaler, and pulses start. The engine captures this configuration. It selects the endpoint, sends the transmit bytes most significant bit first, and then clocks in the receive bytes. Each received byte is written back into the same store, starting at index 0, where software reads it out once the done flag is set.

The controller is a five-state machine:
- `ST_IDLE` goes to `ST_CS_SETUP` on an accepted start.
- `ST_CS_SETUP` waits one half period with the chip select low and the first byte loaded. It then goes to `ST_SEND` if the transmit count is non-zero, to `ST_RECV` if only the receive count is non-zero, and to `ST_CS_HOLD` if both are zero.
- `ST_SEND` goes to `ST_RECV` (or to `ST_CS_HOLD` when nothing is to be received) on the falling clock edge that ends the last transmit byte.
- `ST_RECV` goes to `ST_CS_HOLD` on the falling edge that ends the last receive byte.
- `ST_CS_HOLD` holds the clock low for one half period and then returns to `ST_IDLE`, setting done.

Top module: `qspi_multi_ep`

## Requirements
- R1: After reset `o_busy` and `o_done` are 0, every chip select is high, every serial clock is low and every output enable is 0. Whenever the engine is idle it keeps that same idle pattern on all endpoint lines.
- R2: While a transaction runs, only the chip select of the captured endpoint is low. Every other endpoint keeps its chip select high and its clock low. A clock edge appears only on an endpoint whose chip select is low.
- R3: Transmit data is sent most significant bit first. It changes after a falling clock edge and is stable at the rising edge. Mode 0 (single) uses lane 0. Mode 1 (dual) sends two bits per clock on lanes 1:0, the earlier bit on lane 1. Modes 2 and 3 (quad) send a nibble per clock on lanes 3:0, the earlier bit on lane 3. A transaction gives exactly (tx+rx)·8/b rising edges, where b is the bits per clock.
- R4: Receive data is sampled at the rising clock edge, most significant bit first. Mode 0 samples lane 1 only, mode 1 samples lanes 1:0 (lane 1 first) and quad samples lanes 3:0 (lane 3 first). Unused lanes have no effect. Received byte k is stored at store index k.
- R5: The transmit bytes are read from store indices 0 to tx−1 in order. The receive phase follows the last transmit byte. Store entries at or above the receive count keep their contents.
- R6: The output enable of the selected endpoint is 1 only while transmitting in dual or quad mode. It is 0 in single mode, during the receive phase and for unselected endpoints.
- R7: Each half period of the serial clock lasts (prescaler+1) cycles of `clk`.
- R8: `o_busy` rises in the cycle after an accepted start and falls at the end of the transaction. `o_done` is cleared by an accepted start, set when `o_busy` falls, and held until the next accepted start.
- R9: A start request while busy is ignored. The running transaction keeps its endpoint, its mode and its edge count.
- R10: A software write to the store while busy is ignored.
- R11: A transmit count of 0 goes straight to the receive phase. When both counts are 0 the transaction ends with no clock edge and still sets done.
- R12: A transmit or receive count larger than the store depth is treated as the store depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the engine and the serial clock divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_start | input | 1 | Start request, accepted only when idle |
| i_mode | input | 2 | Lane mode: 0 single, 1 dual, 2 or 3 quad |
| i_ep | input | EPW | Endpoint index |
| i_tx_len | input | LW | Transmit byte count |
| i_rx_len | input | LW | Receive byte count |
| i_presc | input | PRESC_W | Half-period prescaler |
| i_buf_we | input | 1 | Store write strobe from software |
| i_buf_addr | input | AW | Store address for software write and read |
| i_buf_wdata | input | 8 | Store write data |
| o_buf_rdata | output | 8 | Store read data at `i_buf_addr` |
| o_busy | output | 1 | Transaction in progress |
| o_done | output | 1 | Sticky end-of-transaction flag |
| o_csn | output | N_EP | Per-endpoint active-low chip select |
| o_sck | output | N_EP | Per-endpoint serial clock |
| o_sdio_out | output | 4 | Shared outgoing lane data |
| o_sdio_oe | output | N_EP | Per-endpoint lane output enable |
| i_sdio_in | input | 4·N_EP | Incoming lane data, 4 bits per endpoint |

## Verification
The bench sweeps every lane mode against both endpoints and against transfer shapes that are transmit-only, receive-only, mixed, full-depth, empty and over-long, with the prescaler rotating through three values. Rebuilding the transmit bytes from the lane values seen at rising edges separates lane order, lane selection and shift width. Distinct receive patterns, with fixed junk on the unused lanes, separate the store order from wrong sampling lanes. Reading back the store above the receive count, together with pokes during the transaction, tells stray writes and restarted transactions apart from a clean run.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_CS_SETUP = 3'd1,
        ST_SEND     = 3'd2,
        ST_RECV     = 3'd3,
        ST_CS_HOLD  = 3'd4
    } eng_state_e;

    // last unit index within a byte for the lane mode (8/b - 1)
    function automatic logic [2:0] last_unit(input logic [1:0] mode);
        case (mode)
            2'd0:    return 3'd7;
            2'd1:    return 3'd3;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic [3:0] out_lanes(input logic [1:0] mode, input logic [7:0] sr);
        case (mode)
            2'd0:    return {3'b000, sr[7]};
            2'd1:    return {2'b00, sr[7:6]};
            default: return sr[7:4];
        endcase
    endfunction

    function automatic logic [7:0] shift_out(input logic [1:0] mode, input logic [7:0] sr);
        case (mode)
            2'd0:    return {sr[6:0], 1'b0};
            2'd1:    return {sr[5:0], 2'b00};
            default: return {sr[3:0], 4'b0000};
        endcase
    endfunction

    function automatic logic [7:0] shift_in(input logic [1:0] mode, input logic [7:0] sr,
                                            input logic [3:0] lanes);
        case (mode)
            2'd0:    return {sr[6:0], lanes[1]};
            2'd1:    return {sr[5:0], lanes[1:0]};
            default: return {sr[3:0], lanes};
        endcase
    endfunction

endpackage

// File: rtl/qspi_tick_gen.sv
module qspi_tick_gen #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);

    logic [PRESC_W-1:0] cnt_q;

    assign tick = en && (cnt_q == presc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRESC_W'(1);
        end
    end

endmodule

// File: rtl/qspi_byte_buf.sv
module qspi_byte_buf #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          sw_we,
    input  logic [AW-1:0] sw_addr,
    input  logic [7:0]    sw_wdata,
    output logic [7:0]    sw_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_waddr,
    input  logic [7:0]    eng_wdata,
    input  logic [AW-1:0] eng_raddr,
    output logic [7:0]    eng_rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (eng_we) begin
            mem[eng_waddr] <= eng_wdata;
        end else if (sw_we) begin
            mem[sw_addr] <= sw_wdata;
        end
    end

    assign sw_rdata  = mem[sw_addr];
    assign eng_rdata = mem[eng_raddr];

endmodule

// File: rtl/qspi_multi_ep.sv
module qspi_multi_ep #(
    parameter  int N_EP      = 4,
    parameter  int BUF_DEPTH = 16,
    parameter  int PRESC_W   = 8,
    localparam int EPW       = (N_EP > 1) ? $clog2(N_EP) : 1,
    localparam int AW        = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
    localparam int LW        = $clog2(BUF_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                i_start,
    input  logic [1:0]          i_mode,
    input  logic [EPW-1:0]      i_ep,
    input  logic [LW-1:0]       i_tx_len,
    input  logic [LW-1:0]       i_rx_len,
    input  logic [PRESC_W-1:0]  i_presc,
    input  logic                i_buf_we,
    input  logic [AW-1:0]       i_buf_addr,
    input  logic [7:0]          i_buf_wdata,
    output logic [7:0]          o_buf_rdata,
    output logic                o_busy,
    output logic                o_done,
    output logic [N_EP-1:0]     o_csn,
    output logic [N_EP-1:0]     o_sck,
    output logic [3:0]          o_sdio_out,
    output logic [N_EP-1:0]     o_sdio_oe,
    input  logic [4*N_EP-1:0]   i_sdio_in
);

    import qspi_pkg::*;

    localparam logic [LW-1:0] DEPTH_L = LW'(BUF_DEPTH);

    eng_state_e          state_q, state_d;
    logic [EPW-1:0]      ep_q;
    logic [1:0]          mode_q;
    logic [PRESC_W-1:0]  presc_q;
    logic [LW-1:0]       tx_len_q, rx_len_q, idx_q, idx_nxt;
    logic [2:0]          unit_q;
    logic                sck_q, done_q;
    logic [7:0]          tx_sr, rx_sr;
    logic                busy, tick, unit_last, tx_last, rx_last, fall_tick;
    logic                eng_we;
    logic [AW-1:0]       eng_raddr;
    logic [7:0]          eng_rdata;
    logic [3:0]          lanes_in;

    assign busy      = (state_q != ST_IDLE);
    assign unit_last = (unit_q == last_unit(mode_q));
    assign idx_nxt   = idx_q + LW'(1);
    assign tx_last   = (idx_nxt == tx_len_q);
    assign rx_last   = (idx_nxt == rx_len_q);
    assign fall_tick = tick && sck_q;
    assign eng_raddr = (state_q == ST_CS_SETUP) ? '0 : idx_nxt[AW-1:0];
    assign eng_we    = (state_q == ST_RECV) && fall_tick && unit_last;

    qspi_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .presc (presc_q),
        .tick  (tick)
    );

    qspi_byte_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
        .clk       (clk),
        .sw_we     (i_buf_we && !busy),
        .sw_addr   (i_buf_addr),
        .sw_wdata  (i_buf_wdata),
        .sw_rdata  (o_buf_rdata),
        .eng_we    (eng_we),
        .eng_waddr (idx_q[AW-1:0]),
        .eng_wdata (rx_sr),
        .eng_raddr (eng_raddr),
        .eng_rdata (eng_rdata)
    );

    // lane input of the captured endpoint
    always_comb begin
        lanes_in = '0;
        for (int e = 0; e < N_EP; e++) begin
            if (ep_q == EPW'(e)) lanes_in = i_sdio_in[e*4 +: 4];
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (i_start) state_d = ST_CS_SETUP;
            ST_CS_SETUP: if (tick) begin
                             if (tx_len_q != '0)      state_d = ST_SEND;
                             else if (rx_len_q != '0) state_d = ST_RECV;
                             else                     state_d = ST_CS_HOLD;
                         end
            ST_SEND:     if (fall_tick && unit_last && tx_last)
                             state_d = (rx_len_q != '0) ? ST_RECV : ST_CS_HOLD;
            ST_RECV:     if (fall_tick && unit_last && rx_last) state_d = ST_CS_HOLD;
            ST_CS_HOLD:  if (tick) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ep_q     <= '0;
            mode_q   <= '0;
            presc_q  <= '0;
            tx_len_q <= '0;
            rx_len_q <= '0;
            idx_q    <= '0;
            unit_q   <= '0;
            sck_q    <= 1'b0;
            done_q   <= 1'b0;
            tx_sr    <= '0;
            rx_sr    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (i_start) begin
                    ep_q     <= i_ep;
                    mode_q   <= i_mode;
                    presc_q  <= i_presc;
                    tx_len_q <= (i_tx_len > DEPTH_L) ? DEPTH_L : i_tx_len;
                    rx_len_q <= (i_rx_len > DEPTH_L) ? DEPTH_L : i_rx_len;
                    idx_q    <= '0;
                    unit_q   <= '0;
                    sck_q    <= 1'b0;
                    done_q   <= 1'b0;
                end
                ST_CS_SETUP: if (tick) tx_sr <= eng_rdata;
                ST_SEND: if (tick) begin
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                    end else begin
                        sck_q <= 1'b0;
                        if (unit_last) begin
                            unit_q <= '0;
                            idx_q  <= tx_last ? '0 : idx_nxt;
                            tx_sr  <= eng_rdata;
                        end else begin
                            unit_q <= unit_q + 3'd1;
                            tx_sr  <= shift_out(mode_q, tx_sr);
                        end
                    end
                end
                ST_RECV: if (tick) begin
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        rx_sr <= shift_in(mode_q, rx_sr, lanes_in);
                    end else begin
                        sck_q <= 1'b0;
                        if (unit_last) begin
                            unit_q <= '0;
                            idx_q  <= idx_nxt;
                        end else begin
                            unit_q <= unit_q + 3'd1;
                        end
                    end
                end
                ST_CS_HOLD: if (tick) done_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign o_busy     = busy;
    assign o_done     = done_q;
    assign o_sdio_out = (state_q == ST_SEND) ? out_lanes(mode_q, tx_sr) : 4'b0000;

    for (genvar e = 0; e < N_EP; e++) begin : g_ep
        logic sel;
        assign sel          = busy && (ep_q == EPW'(e));
        assign o_csn[e]     = !sel;
        assign o_sck[e]     = sel && sck_q;
        assign o_sdio_oe[e] = sel && (state_q == ST_SEND) && (mode_q != 2'd0);
    end

endmodule

// File: rtl/qspi_multi_ep_chk.sv
module qspi_multi_ep_chk #(
    parameter int N_EP = 4,
    parameter int EPW  = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            i_start,
    input logic            o_busy,
    input logic            o_done,
    input logic [N_EP-1:0] o_csn,
    input logic [N_EP-1:0] o_sck,
    input logic [N_EP-1:0] o_sdio_oe,
    input logic [EPW-1:0]  ep_q,
    input logic [1:0]      mode_q
);

    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !o_busy |-> ((&o_csn) && (o_sck == '0) && (o_sdio_oe == '0)));

    p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~o_csn) <= 1);

    for (genvar e = 0; e < N_EP; e++) begin : g_chk
        p_clock_needs_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
            o_sck[e] |-> !o_csn[e]);
    end

    p_oe_not_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|o_sdio_oe) |-> (mode_q != 2'd0));

    p_start_sets_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (i_start && !o_busy) |=> (o_busy && !o_done));

    p_done_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(o_busy) |-> o_done);

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (i_start && o_busy) |=> ($stable(ep_q) && $stable(mode_q)));

endmodule

bind qspi_multi_ep qspi_multi_ep_chk #(.N_EP(N_EP), .EPW(EPW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .i_start   (i_start),
    .o_busy    (o_busy),
    .o_done    (o_done),
    .o_csn     (o_csn),
    .o_sck     (o_sck),
    .o_sdio_oe (o_sdio_oe),
    .ep_q      (ep_q),
    .mode_q    (mode_q)
);

// File: tb/test_qspi_multi_ep.sv
`timescale 1ns/1ps
module test_qspi_multi_ep;

    localparam int N_EP    = 2;
    localparam int DEPTH   = 8;
    localparam int PRESC_W = 4;
    localparam int EPW     = 1;
    localparam int AW      = 3;
    localparam int LW      = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic i_start = 1'b0;
    logic [1:0] i_mode = '0;
    logic [EPW-1:0] i_ep = '0;
    logic [LW-1:0] i_tx_len = '0, i_rx_len = '0;
    logic [PRESC_W-1:0] i_presc = '0;
    logic i_buf_we = 1'b0;
    logic [AW-1:0] i_buf_addr = '0;
    logic [7:0] i_buf_wdata = '0;
    logic [7:0] o_buf_rdata;
    logic o_busy, o_done;
    logic [N_EP-1:0] o_csn, o_sck, o_sdio_oe;
    logic [3:0] o_sdio_out;
    logic [4*N_EP-1:0] i_sdio_in;

    always #5 clk = ~clk;

    qspi_multi_ep #(.N_EP(N_EP), .BUF_DEPTH(DEPTH), .PRESC_W(PRESC_W)) i_qspi_multi_ep (
        .clk, .rst_n, .i_start, .i_mode, .i_ep, .i_tx_len, .i_rx_len, .i_presc,
        .i_buf_we, .i_buf_addr, .i_buf_wdata, .o_buf_rdata, .o_busy, .o_done,
        .o_csn, .o_sck, .o_sdio_out, .o_sdio_oe, .i_sdio_in
    );

    int checks = 0, failures = 0;
    int cur_ep = 0, cur_mode = 0, cur_seed = 0, tx_units = 0;
    int poscnt = 0, negcnt = 0;
    bit idle_viol = 1'b0;
    longint t_first = 0, t_second = 0;
    logic [3:0] cap_l [256];
    logic [N_EP-1:0] cap_oe [256];
    logic sck_sel;

    assign sck_sel = o_sck[cur_ep];

    function automatic int units_of(input int mode);
        return (mode == 0) ? 8 : (mode == 1) ? 4 : 2;
    endfunction

    function automatic logic [7:0] tx_byte(input int k, input int seed);
        return 8'((k * 53 + seed * 29 + 60) ^ 150);
    endfunction

    function automatic logic [7:0] rx_byte(input int k, input int seed);
        return 8'((k * 71 + seed * 13 + 90) ^ 33);
    endfunction

    // lane values presented for receive unit n, junk on unused lanes
    function automatic logic [3:0] rx_drive(input int n, input int mode, input int seed, input int txu);
        int r, u, units, bpc;
        logic [7:0] b;
        logic [3:0] f;
        r = n - txu;
        if (r < 0) return 4'h0;
        units = units_of(mode);
        bpc = 8 / units;
        b = rx_byte(r / units, seed);
        u = r % units;
        f = 4'((b >> (8 - bpc * (u + 1))) & ((1 << bpc) - 1));
        case (mode)
            0: return {2'b10, f[0], 1'b1};
            1: return {2'b11, f[1:0]};
            default: return f;
        endcase
    endfunction

    always_comb begin
        for (int e = 0; e < N_EP; e++)
            i_sdio_in[e*4 +: 4] = (e == cur_ep) ? rx_drive(negcnt, cur_mode, cur_seed, tx_units) : 4'hF;
    end

    always @(posedge sck_sel) begin
        if (poscnt < 256) begin
            cap_l[poscnt]  = o_sdio_out;
            cap_oe[poscnt] = o_sdio_oe;
        end
        if (poscnt == 0) t_first = $time;
        if (poscnt == 1) t_second = $time;
        poscnt++;
    end

    always @(negedge sck_sel) negcnt++;

    always @(negedge clk) begin
        if (o_busy) begin
            for (int e = 0; e < N_EP; e++)
                if (e != cur_ep && (!o_csn[e] || o_sck[e])) idle_viol = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_xfer(input int mode, input int ep, input int txl, input int rxl,
                            input int presc, input int seed, input bit poke);
        int units, bpc, txe, rxe, w, exp_edges;
        int e3, e4, e5, e10, a3, x3, a4, x4;
        logic [7:0] b;
        logic [7:0] exp_b;
        units = units_of(mode);
        bpc = 8 / units;
        txe = (txl > DEPTH) ? DEPTH : txl;
        rxe = (rxl > DEPTH) ? DEPTH : rxl;
        exp_edges = (txe + rxe) * units;
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            i_buf_we = 1'b1; i_buf_addr = AW'(k); i_buf_wdata = tx_byte(k, seed);
        end
        @(negedge clk);
        i_buf_we = 1'b0;
        cur_mode = mode; cur_ep = ep; cur_seed = seed; tx_units = txe * units;
        poscnt = 0; negcnt = 0; idle_viol = 1'b0; t_first = 0; t_second = 0;
        i_mode = 2'(mode); i_ep = EPW'(ep); i_tx_len = LW'(txl); i_rx_len = LW'(rxl);
        i_presc = PRESC_W'(presc); i_start = 1'b1;
        @(negedge clk);
        i_start = 1'b0;
        chk(o_busy && !o_done, "R8 busy after start", {o_busy, o_done}, 2);
        chk(!o_csn[ep], "R2 selected chip select low", o_csn[ep], 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            i_start = 1'b1; i_ep = EPW'(ep ^ 1); i_mode = 2'((mode + 1) % 3);
            i_buf_we = 1'b1; i_buf_addr = AW'(DEPTH - 1); i_buf_wdata = ~tx_byte(DEPTH - 1, seed);
            @(negedge clk);
            i_start = 1'b0; i_buf_we = 1'b0;
        end
        w = 0;
        while (!o_done && w < 20000) begin
            @(negedge clk);
            w++;
        end
        chk(o_done && !o_busy, "R8 done at end", {o_done, o_busy}, 2);
        chk(&o_csn && o_sck == '0, "R1 idle lines after end", {o_csn, o_sck}, {2'b11, 2'b00});
        chk(poscnt == exp_edges, (txl > DEPTH) ? "R12 clamped edge count" :
            (txl == 0) ? "R11 edge count" : "R3 edge count", poscnt, exp_edges);
        if (poke) chk(poscnt == exp_edges && !idle_viol, "R9 start while busy ignored", poscnt, exp_edges);
        e3 = 0; a3 = 0; x3 = 0; e5 = 0;
        for (int bi = 0; bi < txe; bi++) begin
            b = '0;
            for (int u = 0; u < units; u++) begin
                logic [3:0] l;
                l = cap_l[bi * units + u];
                case (mode)
                    0: b = {b[6:0], l[0]};
                    1: b = {b[5:0], l[1:0]};
                    default: b = {b[3:0], l};
                endcase
            end
            if (b != tx_byte(bi, seed) && e3 == 0) begin a3 = b; x3 = tx_byte(bi, seed); end
            if (b != tx_byte(bi, seed)) e3++;
        end
        if (txe > 0) chk(e3 == 0, "R3 transmitted bytes", a3, x3);
        e4 = 0;
        for (int n = 0; n < exp_edges && n < 256; n++) begin
            logic [N_EP-1:0] eo;
            eo = (n < txe * units && mode != 0) ? N_EP'(1 << ep) : '0;
            if (cap_oe[n] != eo) e4++;
        end
        chk(e4 == 0, "R6 output enable", e4, 0);
        if (exp_edges >= 2) chk(t_second - t_first == 2 * (presc + 1) * 10, "R7 clock period",
                                t_second - t_first, 2 * (presc + 1) * 10);
        chk(!idle_viol, "R2 other endpoints idle", idle_viol, 0);
        e4 = 0; a4 = 0; x4 = 0; e10 = 0;
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            i_buf_addr = AW'(k);
            #1;
            exp_b = (k < rxe) ? rx_byte(k, seed) : tx_byte(k, seed);
            if (o_buf_rdata != exp_b) begin
                if (k < rxe) begin
                    if (e4 == 0) begin a4 = o_buf_rdata; x4 = exp_b; end
                    e4++;
                end else if (poke && k == DEPTH - 1) e10++;
                else e5++;
            end
        end
        if (rxe > 0) chk(e4 == 0, "R4 received bytes in store", a4, x4);
        chk(e5 == 0, "R5 store above receive count kept", e5, 0);
        if (poke && rxe < DEPTH) chk(e10 == 0, "R10 write while busy ignored", e10, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        int txs [7] = '{1, 0, 2, 8, 3, 0, 12};
        int rxs [7] = '{0, 1, 3, 5, 1, 0, 2};
        repeat (3) @(negedge clk);
        chk(!o_busy && !o_done, "R1 reset status", {o_busy, o_done}, 0);
        chk(&o_csn && o_sck == '0 && o_sdio_oe == '0, "R1 reset lines", {o_csn, o_sck, o_sdio_oe}, 6'b110000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!o_busy && &o_csn, "R1 idle after reset", {o_busy, o_csn}, 3);
        seed = 1;
        for (int m = 0; m < 3; m++)
            for (int ep = 0; ep < N_EP; ep++)
                for (int c = 0; c < 7; c++) begin
                    run_xfer(m, ep, txs[c], rxs[c], (c + m) % 3, seed, (c == 2 || c == 3));
                    seed++;
                end
        // mode code 3 behaves as quad
        run_xfer(3, 1, 2, 2, 1, seed, 1'b0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule